// File: doc/BRIEF.md
# Register ALU with Condition Flag

This block is the execute stage for the register operations of a 16-bit machine. Each cycle it receives the first byte of an instruction as an operation code, the value of the source register (S field), the value of the destination register (D field) and the current status word. One clock later it presents the result to write back, a write-back enable and the status word that follows the operation.

The two-operand arithmetic and bitwise operations combine D with S and write the result to D. `mov` copies S. The single-register operations (`neg`, `not`, `inc`, `dec`) act on the D operand. The three compare forms (`test`, `cmp`, `equ`) write nothing back. They change only bit 0 of the status word, which is the condition flag that later branches read. Every other status bit passes through unchanged.

Operation codes outside the supported set have no effect: no write-back and no status change. Memory, stack and control-flow operations belong to other stages.

Top module: `alu_exec`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `result`, `wb_en` and `flags_out` are all zero.
- R2: Outputs are registered. The values for an operation presented before a rising clock edge appear after that edge. A new operation can be accepted on every cycle.
- R3: Opcode 0x81 gives D+S, 0x82 gives D−S and 0x83 gives the low 16 bits of D×S. All results wrap modulo 2^16.
- R4: Opcode 0x85 gives D&S, 0x86 gives D|S and 0x87 gives D^S.
- R5: Opcode 0x8D gives S, and the D operand has no effect on the result.
- R6: Opcode 0x41 gives the two's-complement negation of D, 0x42 gives ~D, 0x48 gives D+1 and 0x49 gives D−1. All four wrap modulo 2^16.
- R7: Opcode 0x8A sets `flags_out[0]` to 1 when S&D is nonzero and to 0 otherwise.
- R8: Opcode 0x8B sets `flags_out[0]` to 1 when S<D as unsigned values and to 0 otherwise.
- R9: Opcode 0x8C sets `flags_out[0]` to 1 when S equals D and to 0 otherwise.
- R10: The compare opcodes 0x8A, 0x8B and 0x8C keep `flags_in[15:1]` in `flags_out[15:1]`. They drive `wb_en` to 0 and `result` to 0.
- R11: For every supported opcode that is not a compare, `wb_en` is 1 and `flags_out` equals `flags_in`.
- R12: For any other opcode, `wb_en` is 0, `result` is 0 and `flags_out` equals `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 8 | First instruction byte that selects the operation |
| src_s | input | 16 | Value of the register in the S field |
| src_d | input | 16 | Value of the register in the D field |
| flags_in | input | 16 | Current status word |
| result | output | 16 | Value to write to the D register |
| wb_en | output | 1 | Write-back enable for `result` |
| flags_out | output | 16 | Status word after the operation |

## Verification
The only state in the block is the single output register. A wrong decode, operand swap or flag merge therefore shows at the ports on the edge right after the operation is presented. It cannot be hidden by a later cycle. The likely faults are a swapped S/D order in `sub` or `cmp`, a signed comparison in place of an unsigned one, a compare that disturbs the upper status bits or asserts write-back, and an unknown opcode that leaks a write. Back-to-back operations with alternating groups show whether any value is carried from one cycle into the next.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

    typedef enum logic [3:0] {
        K_NONE, K_ADD, K_SUB, K_MUL, K_AND, K_OR, K_XOR, K_MOV,
        K_NEG, K_NOT, K_INC, K_DEC, K_TST, K_CMP, K_EQU
    } op_kind_e;

    typedef enum logic [1:0] {
        G_NONE, G_ARITH, G_LOGIC, G_COND
    } op_grp_e;

    localparam logic [7:0] OPC_ADD = 8'h81;
    localparam logic [7:0] OPC_SUB = 8'h82;
    localparam logic [7:0] OPC_MUL = 8'h83;
    localparam logic [7:0] OPC_AND = 8'h85;
    localparam logic [7:0] OPC_OR  = 8'h86;
    localparam logic [7:0] OPC_XOR = 8'h87;
    localparam logic [7:0] OPC_TST = 8'h8A;
    localparam logic [7:0] OPC_CMP = 8'h8B;
    localparam logic [7:0] OPC_EQU = 8'h8C;
    localparam logic [7:0] OPC_MOV = 8'h8D;
    localparam logic [7:0] OPC_NEG = 8'h41;
    localparam logic [7:0] OPC_NOT = 8'h42;
    localparam logic [7:0] OPC_INC = 8'h48;
    localparam logic [7:0] OPC_DEC = 8'h49;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_exec_pkg::*;
(
    input  logic [7:0] opc,
    output op_kind_e   kind,
    output op_grp_e    grp
);

    always_comb begin
        kind = K_NONE;
        unique case (opc)
            OPC_ADD: kind = K_ADD;
            OPC_SUB: kind = K_SUB;
            OPC_MUL: kind = K_MUL;
            OPC_AND: kind = K_AND;
            OPC_OR:  kind = K_OR;
            OPC_XOR: kind = K_XOR;
            OPC_MOV: kind = K_MOV;
            OPC_NEG: kind = K_NEG;
            OPC_NOT: kind = K_NOT;
            OPC_INC: kind = K_INC;
            OPC_DEC: kind = K_DEC;
            OPC_TST: kind = K_TST;
            OPC_CMP: kind = K_CMP;
            OPC_EQU: kind = K_EQU;
            default: kind = K_NONE;
        endcase
    end

    always_comb begin
        unique case (kind)
            K_ADD, K_SUB, K_MUL, K_NEG, K_INC, K_DEC: grp = G_ARITH;
            K_AND, K_OR, K_XOR, K_NOT, K_MOV:         grp = G_LOGIC;
            K_TST, K_CMP, K_EQU:                      grp = G_COND;
            default:                                  grp = G_NONE;
        endcase
    end

endmodule

// File: rtl/alu_arith.sv
module alu_arith
    import alu_exec_pkg::*;
#(
    parameter int W = 16
) (
    input  op_kind_e       kind,
    input  logic [W-1:0]   opnd_s,
    input  logic [W-1:0]   opnd_d,
    output logic [W-1:0]   res
);

    localparam int PW = 2 * W;

    logic [PW-1:0] prod;
    logic [W-1:0]  one;

    assign one  = W'(1);
    assign prod = PW'(opnd_d) * PW'(opnd_s);

    always_comb begin
        res = '0;
        unique case (kind)
            K_ADD:   res = opnd_d + opnd_s;
            K_SUB:   res = opnd_d - opnd_s;
            K_MUL:   res = prod[W-1:0];
            K_NEG:   res = (~opnd_d) + one;
            K_INC:   res = opnd_d + one;
            K_DEC:   res = opnd_d - one;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_exec_pkg::*;
#(
    parameter int W = 16
) (
    input  op_kind_e       kind,
    input  logic [W-1:0]   opnd_s,
    input  logic [W-1:0]   opnd_d,
    output logic [W-1:0]   res
);

    always_comb begin
        res = '0;
        unique case (kind)
            K_AND:   res = opnd_d & opnd_s;
            K_OR:    res = opnd_d | opnd_s;
            K_XOR:   res = opnd_d ^ opnd_s;
            K_NOT:   res = ~opnd_d;
            K_MOV:   res = opnd_s;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alu_cond.sv
module alu_cond
    import alu_exec_pkg::*;
#(
    parameter int W = 16
) (
    input  op_kind_e       kind,
    input  logic [W-1:0]   opnd_s,
    input  logic [W-1:0]   opnd_d,
    input  logic [W-1:0]   stat_in,
    output logic [W-1:0]   stat_next
);

    logic hit_and;
    logic hit_lt;
    logic hit_eq;
    logic cond_bit;

    assign hit_and = |(opnd_s & opnd_d);
    assign hit_lt  = (opnd_s < opnd_d);
    assign hit_eq  = (opnd_s == opnd_d);

    always_comb begin
        unique case (kind)
            K_TST:   cond_bit = hit_and;
            K_CMP:   cond_bit = hit_lt;
            K_EQU:   cond_bit = hit_eq;
            default: cond_bit = stat_in[0];
        endcase
    end

    assign stat_next = {stat_in[W-1:1], cond_bit};

endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_exec_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    opcode,
    input  logic [W-1:0]  src_s,
    input  logic [W-1:0]  src_d,
    input  logic [W-1:0]  flags_in,
    output logic [W-1:0]  result,
    output logic          wb_en,
    output logic [W-1:0]  flags_out
);

    typedef struct packed {
        logic [W-1:0] res;
        logic         wb;
        logic [W-1:0] flg;
    } stage_t;

    op_kind_e      kind;
    op_grp_e       grp;
    logic [W-1:0]  arith_res;
    logic [W-1:0]  logic_res;
    logic [W-1:0]  cond_flg;
    stage_t        stage_d;
    stage_t        stage_q;

    alu_decode u_dec (
        .opc  (opcode),
        .kind (kind),
        .grp  (grp)
    );

    alu_arith #(.W(W)) u_arith (
        .kind   (kind),
        .opnd_s (src_s),
        .opnd_d (src_d),
        .res    (arith_res)
    );

    alu_logic #(.W(W)) u_logic (
        .kind   (kind),
        .opnd_s (src_s),
        .opnd_d (src_d),
        .res    (logic_res)
    );

    alu_cond #(.W(W)) u_cond (
        .kind      (kind),
        .opnd_s    (src_s),
        .opnd_d    (src_d),
        .stat_in   (flags_in),
        .stat_next (cond_flg)
    );

    always_comb begin
        stage_d     = '0;
        stage_d.flg = flags_in;
        unique case (grp)
            G_ARITH: begin
                stage_d.res = arith_res;
                stage_d.wb  = 1'b1;
            end
            G_LOGIC: begin
                stage_d.res = logic_res;
                stage_d.wb  = 1'b1;
            end
            G_COND: begin
                stage_d.flg = cond_flg;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign result    = stage_q.res;
    assign wb_en     = stage_q.wb;
    assign flags_out = stage_q.flg;

    AST_COND_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == G_COND) |=> (!wb_en && result == '0)); // R10

    AST_COND_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == G_COND) |=> (flags_out[W-1:1] == $past(flags_in[W-1:1]))); // R10

    AST_WORK_FLAGS_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == G_ARITH || grp == G_LOGIC) |=> (wb_en && flags_out == $past(flags_in))); // R11

    AST_UNKNOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == G_NONE) |=> (!wb_en && result == '0 && flags_out == $past(flags_in))); // R12

    AST_MOV_IGNORES_D: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_MOV) |=> (result == $past(src_s))); // R5

endmodule

// File: tb/sim_alu_exec.sv
`timescale 1ns/1ps
module sim_alu_exec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] src_s = 16'h0;
    logic [15:0] src_d = 16'h0;
    logic [15:0] flags_in = 16'h0;
    logic [15:0] result;
    logic        wb_en;
    logic [15:0] flags_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    alu_exec u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (opcode),
        .src_s     (src_s),
        .src_d     (src_d),
        .flags_in  (flags_in),
        .result    (result),
        .wb_en     (wb_en),
        .flags_out (flags_out)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the next rising edge.
    task automatic run_op(input logic [7:0] op, input logic [15:0] s, input logic [15:0] d, input logic [15:0] f);
        @(negedge clk);
        opcode = op; src_s = s; src_d = d; flags_in = f;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_wr(input string req, input logic [7:0] op, input logic [15:0] s,
                             input logic [15:0] d, input logic [15:0] f, input logic [15:0] exp_res);
        run_op(op, s, d, f);
        chk(req, $sformatf("result op=%h", op), {16'h0, result}, {16'h0, exp_res});
        chk("R11", $sformatf("wb_en op=%h", op), {31'h0, wb_en}, 32'h1);
        chk("R11", $sformatf("flags op=%h", op), {16'h0, flags_out}, {16'h0, f});
    endtask

    task automatic expect_cond(input string req, input logic [7:0] op, input logic [15:0] s,
                               input logic [15:0] d, input logic [15:0] f, input logic bit0);
        run_op(op, s, d, f);
        chk(req, $sformatf("flag bit op=%h s=%h d=%h", op, s, d), {31'h0, flags_out[0]}, {31'h0, bit0});
        chk("R10", "upper flags", {17'h0, flags_out[15:1]}, {17'h0, f[15:1]});
        chk("R10", "no write-back", {31'h0, wb_en}, 32'h0);
        chk("R10", "result zero", {16'h0, result}, 32'h0);
    endtask

    task automatic t_reset;
        opcode = 8'h81; src_s = 16'h1234; src_d = 16'h1111; flags_in = 16'hFFFF;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "result in reset", {16'h0, result}, 32'h0);
        chk("R1", "wb_en in reset", {31'h0, wb_en}, 32'h0);
        chk("R1", "flags in reset", {16'h0, flags_out}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        opcode = 8'h00;
        #0.5;
        chk("R1", "result just after reset", {16'h0, result}, 32'h0);
        chk("R1", "flags just after reset", {16'h0, flags_out}, 32'h0);
    endtask

    task automatic t_arith;
        expect_wr("R3", 8'h81, 16'h0003, 16'h0004, 16'hA5A4, 16'h0007);
        expect_wr("R3", 8'h81, 16'h0001, 16'hFFFF, 16'h0001, 16'h0000);
        expect_wr("R3", 8'h82, 16'h0005, 16'h0003, 16'h0000, 16'hFFFE);
        expect_wr("R3", 8'h82, 16'h0010, 16'h0030, 16'h8001, 16'h0020);
        expect_wr("R3", 8'h83, 16'h0004, 16'h0003, 16'h0000, 16'h000C);
        expect_wr("R3", 8'h83, 16'h1234, 16'h0100, 16'h0000, 16'h3400);
    endtask

    task automatic t_logic;
        expect_wr("R4", 8'h85, 16'hF0F0, 16'hFF00, 16'h0000, 16'hF000);
        expect_wr("R4", 8'h86, 16'hF0F0, 16'h0F00, 16'h0002, 16'hFFF0);
        expect_wr("R4", 8'h87, 16'hAAAA, 16'hFFFF, 16'h0000, 16'h5555);
        expect_wr("R5", 8'h8D, 16'hBEEF, 16'h1234, 16'h0000, 16'hBEEF);
        expect_wr("R5", 8'h8D, 16'hBEEF, 16'hFFFF, 16'h0000, 16'hBEEF);
    endtask

    task automatic t_unary;
        expect_wr("R6", 8'h41, 16'hFFFF, 16'h0001, 16'h0000, 16'hFFFF);
        expect_wr("R6", 8'h41, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        expect_wr("R6", 8'h42, 16'h0000, 16'h00FF, 16'h0000, 16'hFF00);
        expect_wr("R6", 8'h48, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000);
        expect_wr("R6", 8'h49, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF);
        expect_wr("R6", 8'h49, 16'h7777, 16'h0010, 16'h0000, 16'h000F);
    endtask

    task automatic t_compare;
        expect_cond("R7", 8'h8A, 16'h0F00, 16'h0100, 16'hFFFE, 1'b1);
        expect_cond("R7", 8'h8A, 16'h0F00, 16'h00F0, 16'hFFFF, 1'b0);
        expect_cond("R8", 8'h8B, 16'h0001, 16'h0002, 16'h0000, 1'b1);
        expect_cond("R8", 8'h8B, 16'h0002, 16'h0001, 16'h0001, 1'b0);
        expect_cond("R8", 8'h8B, 16'h0005, 16'h0005, 16'h0001, 1'b0);
        expect_cond("R8", 8'h8B, 16'h0001, 16'h8000, 16'h5554, 1'b1);
        expect_cond("R8", 8'h8B, 16'hFFFF, 16'h0001, 16'hAAAB, 1'b0);
        expect_cond("R9", 8'h8C, 16'h1234, 16'h1234, 16'h8000, 1'b1);
        expect_cond("R9", 8'h8C, 16'h1234, 16'h1235, 16'h7FFF, 1'b0);
    endtask

    task automatic t_unknown;
        logic [7:0] bad [5] = '{8'h00, 8'h84, 8'h8E, 8'hE1, 8'h43};
        foreach (bad[i]) begin
            run_op(bad[i], 16'h1234, 16'h5678, 16'hC3C3);
            chk("R12", $sformatf("wb_en op=%h", bad[i]), {31'h0, wb_en}, 32'h0);
            chk("R12", $sformatf("result op=%h", bad[i]), {16'h0, result}, 32'h0);
            chk("R12", $sformatf("flags op=%h", bad[i]), {16'h0, flags_out}, 32'hC3C3);
        end
    endtask

    task automatic t_stream;
        // One operation per cycle; each edge reflects only the operation before it.
        @(negedge clk);
        opcode = 8'h81; src_s = 16'h0002; src_d = 16'h0003; flags_in = 16'h0010;
        @(posedge clk);
        #1;
        chk("R2", "add in stream", {16'h0, result}, 32'h0005);
        @(negedge clk);
        chk("R2", "held until edge", {16'h0, result}, 32'h0005);
        opcode = 8'h8C; src_s = 16'h0007; src_d = 16'h0007; flags_in = 16'h0010;
        @(posedge clk);
        #1;
        chk("R2", "equ in stream flags", {16'h0, flags_out}, 32'h0011);
        chk("R2", "equ in stream wb", {31'h0, wb_en}, 32'h0);
        @(negedge clk);
        opcode = 8'h49; src_s = 16'h0000; src_d = 16'h0001; flags_in = 16'h0011;
        @(posedge clk);
        #1;
        chk("R2", "dec in stream", {16'h0, result}, 32'h0000);
        chk("R2", "dec in stream wb", {31'h0, wb_en}, 32'h1);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_logic();
        t_unary();
        t_compare();
        t_unknown();
        t_stream();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule